// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block gathers eight single-cycle event pulses from a UART's transmit and receive paths and turns them into latched interrupt status bits. Each source has an enable bit. A pulse latches its status bit only while that source is enabled, and the bit then stays set until software clears it. Software clears a bit by writing a one to its position in a clear register.

Each of the eight interrupt lines normally shows its status bit gated by the enable mask. For integration testing, a test-control bit hands the lines to a software override register. The latched status keeps tracking events while this mode is on, so the status word always reflects the real sources.

Software reaches the block through a plain register port. The port has a one-cycle write strobe with an address and a data byte, and a combinational read selected by a read address. The latched status word is presented on its own read-only output.

Top module: `uart_irq_status`

## Requirements
- R1: Every 8-bit vector in the block uses the same source order: bit 0 transmit, 1 receive, 2 transmit overflow, 3 receive overflow, 4 receive frame error, 5 receive break, 6 receive timeout, 7 receive parity error.
- R2: An event pulse on a source whose enable bit is 1 sets that status bit one clock later, and the bit stays set until it is cleared.
- R3: An event pulse on a source whose enable bit is 0 leaves that status bit unchanged.
- R4: A write to address 1 (clear) clears each status bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. Address 1 always reads as zero.
- R5: If an enabled event and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: With the test-control bit at 0, each irq line equals its status bit ANDed with its enable bit.
- R7: With the test-control bit at 1, each irq line equals the matching bit of the override register.
- R8: Test mode does not touch the status bits. Enabled events still set them, clears still clear them, and status_o still shows them.
- R9: After reset, the enable, test-control, override and status registers are all zero, and every irq line is 0.
- R10: Register addresses are: 0 enable (read/write), 1 clear (write-one-to-clear), 2 test-control in data bit 0 (read/write), 3 override (read/write). Reads return the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | Event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data for rd_addr |
| status_o | output | 8 | Latched status word |
| irq_o | output | 8 | Interrupt lines |

## Verification
A corrupted status bit shows on status_o on the clock edge after the event or clear that caused it. In normal mode it also shows on its irq line on that same edge. A lost enable or override bit shows at once on the combinational read port and on the irq lines. For that reason, every step of the bench compares both the status and irq outputs one edge after the stimulus. The bench also runs events while in test mode and then returns to normal mode, which exposes any status update that test mode blocked.

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int NSRC = 8,
  parameter int AW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [NSRC-1:0] wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [NSRC-1:0] rd_data,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] irq_o
);
  localparam logic [AW-1:0] A_EN  = AW'(0);
  localparam logic [AW-1:0] A_CLR = AW'(1);
  localparam logic [AW-1:0] A_TST = AW'(2);
  localparam logic [AW-1:0] A_OVR = AW'(3);

  logic [NSRC-1:0] en_q, ovr_q, st_q;
  logic            tst_q;
  logic [NSRC-1:0] set_v, clr_v;

  // R2 R3 R5: masked set dominates write-one-to-clear
  assign set_v = evt_i & en_q;
  assign clr_v = (wr_en && wr_addr == A_CLR) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ovr_q <= '0;
      tst_q <= 1'b0;
      st_q  <= '0;
    end else begin
      st_q <= (st_q & ~clr_v) | set_v;
      if (wr_en) begin
        case (wr_addr)
          A_EN:    en_q  <= wr_data;
          A_TST:   tst_q <= wr_data[0];
          A_OVR:   ovr_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign status_o = st_q;
  assign irq_o    = tst_q ? ovr_q : (st_q & en_q);

  always_comb begin
    case (rd_addr)
      A_EN:    rd_data = en_q;
      A_TST:   rd_data = {{(NSRC-1){1'b0}}, tst_q};
      A_OVR:   rd_data = ovr_q;
      default: rd_data = '0;
    endcase
  end

  a_r2_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(evt_i & en_q)) == $past(evt_i & en_q)));

  a_r3_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & ~$past(status_o) & $past(evt_i & ~en_q)) == '0));

  a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CLR) |=>
      ((status_o & $past(wr_data & ~(evt_i & en_q))) == '0));

  a_r4_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_CLR) |-> (rd_data == '0));

  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == '0 && !(wr_en && wr_addr == A_CLR)) |=> $stable(status_o));

  a_r6_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_TST && rd_data[0] == 1'b0) |-> ((irq_o & ~status_o) == '0));
endmodule

// File: tb/test_uart_irq_status.sv
module test_uart_irq_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] evt_i = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data, status_o, irq_o;

  uart_irq_status i_uart_irq_status (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .status_o(status_o), .irq_o(irq_o));

  always #10ns clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [15:0] q_exp[$];
  string q_tag[$];
  logic [7:0] m_en = '0, m_ovr = '0, m_st = '0;
  logic m_tst = 1'b0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] ev, input logic we, input logic [1:0] a,
                      input logic [7:0] d, input string tag);
    logic [7:0] clr;
    @(negedge clk);
    evt_i = ev; wr_en = we; wr_addr = a; wr_data = d;
    clr = (we && a == 2'd1) ? d : 8'h00;
    m_st = (m_st & ~clr) | (ev & m_en);
    if (we) begin
      if (a == 2'd0) m_en = d;
      if (a == 2'd2) m_tst = d[0];
      if (a == 2'd3) m_ovr = d;
    end
    q_exp.push_back({m_st, m_tst ? m_ovr : (m_st & m_en)});
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    evt_i = '0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    evt_i = '0; wr_en = 1'b0; rd_addr = a;
    #1ns chk(tag, rd_data, exp);
  endtask

  always @(posedge clk) begin
    #5ns;
    if (q_exp.size() != 0) begin
      logic [15:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      chk({t, " status"}, status_o, e[15:8]);
      chk({t, " irq"}, irq_o, e[7:0]);
    end
  end

  initial begin
    #2ms;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1ns;
    chk("R9 status", status_o, 8'h00);
    chk("R9 irq", irq_o, 8'h00);
    rd(2'd0, 8'h00, "R9 enable");
    rd(2'd3, 8'h00, "R9 override");
    step(8'hFF, 1'b0, 2'd0, 8'h00, "R3 all disabled");
    step(8'h00, 1'b1, 2'd0, 8'hA5, "R10 write enable");
    rd(2'd0, 8'hA5, "R10 enable readback");
    step(8'hFF, 1'b0, 2'd0, 8'h00, "R2 masked set R1");
    idle();
    step(8'h00, 1'b0, 2'd0, 8'h00, "R2 holds");
    step(8'h00, 1'b1, 2'd1, 8'h00, "R4 zero write");
    step(8'h00, 1'b1, 2'd1, 8'h04, "R4 clear bit2");
    rd(2'd1, 8'h00, "R4 clear reads zero");
    step(8'h00, 1'b1, 2'd0, 8'h0F, "R6 enable mask");
    step(8'h00, 1'b1, 2'd0, 8'hFF, "R6 unmask");
    step(8'h01, 1'b1, 2'd1, 8'h01, "R5 set wins");
    step(8'h02, 1'b1, 2'd1, 8'h01, "R5 other bit");
    step(8'h00, 1'b1, 2'd3, 8'h3C, "R10 override");
    rd(2'd3, 8'h3C, "R10 override readback");
    step(8'h00, 1'b1, 2'd2, 8'h01, "R7 enter test");
    rd(2'd2, 8'h01, "R10 test readback");
    step(8'h40, 1'b0, 2'd0, 8'h00, "R8 event in test");
    step(8'h00, 1'b1, 2'd1, 8'h81, "R8 clear in test");
    step(8'h00, 1'b1, 2'd3, 8'hC3, "R7 new override");
    step(8'h00, 1'b1, 2'd2, 8'h00, "R6 leave test");
    step(8'h00, 1'b1, 2'd1, 8'hFF, "R4 clear all");
    step(8'h80, 1'b0, 2'd0, 8'h00, "R1 parity error bit7");
    idle();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule